// File: doc/BRIEF.md
# Overcurrent Set-Point Tracking Sampler

This block turns an analog overcurrent set-point voltage into a held digital code. After a start request it clears a counter and lets it climb one step per conversion tick. The count drives an external DAC. An external comparator reports when the DAC voltage has reached the sensed set-point. At that point the count is frozen into a hold register. Because the count has to climb all the way up to the set-point, a high set-point takes longer to capture than a low one. The held value does not decay. It stays valid for as long as the bias supply remains above its power-on threshold.

The held code sets the threshold for the switch-node overcurrent comparison. That threshold is twice the sampled value, and it is presented as a separate output. A set-point at or above a ceiling code turns protection off entirely, and the block signals this with a disable flag. The surrounding controller pulses start only when it leaves shutdown. It never pulses start during retry cycles, so the held value stays unchanged across hiccups.

Top module: `ocp_setpoint_sampler`

## Requirements
- R1: While `rst` is high, and after reset, `dac_code`, `held_code`, `trip_level`, `sample_done`, `sample_valid` and `ocp_disabled` are all zero.
- R2: A `start` seen while `por_good` is high clears `dac_code` to 0 at the next edge. During conversion, `dac_code` rises by exactly 1 on each edge where `conv_tick` is high and `cmp_reached` is low. It holds its value on edges where `conv_tick` is low.
- R3: On the first edge during conversion where `cmp_reached` is high, the current `dac_code` is captured into `held_code`. `sample_valid` rises, and `sample_done` is high for exactly one cycle. With `conv_tick` held high and the comparator true once the code is at or above a target T, `sample_done` appears T+1 edges after the start edge.
- R4: If `dac_code` has reached its maximum (2^CODE_W-1, 63 by default) and a tick arrives with `cmp_reached` low, the counter saturates. The maximum code is then captured as if the comparator had fired.
- R5: While `sample_valid` is high, `held_code` keeps its value whatever `cmp_reached` and `conv_tick` do. It changes only when a new `start` arrives or when `por_good` falls.
- R6: `trip_level` equals twice `held_code`, that is, `held_code` shifted left by one bit, with width CODE_W+1.
- R7: `ocp_disabled` is high exactly when a sample is valid and `held_code` is at or above DIS_CODE (40 by default).
- R8: A `start` during conversion or while a value is held restarts the conversion from code 0. `sample_valid`, `held_code` and `ocp_disabled` clear at that same edge.
- R9: While `por_good` is low, all state clears at each edge and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_good | input | 1 | Bias supply above power-on threshold |
| start | input | 1 | Request a new capture (shutdown exit) |
| conv_tick | input | 1 | Conversion step enable |
| cmp_reached | input | 1 | Comparator: DAC voltage at or above set-point |
| dac_code | output | CODE_W | Counter value driving the DAC |
| held_code | output | CODE_W | Captured set-point code |
| trip_level | output | CODE_W+1 | Switch-node trip threshold, twice the held code |
| sample_done | output | 1 | One-cycle pulse when capture completes |
| sample_valid | output | 1 | Held code is valid |
| ocp_disabled | output | 1 | Set-point beyond ceiling, protection off |

## Verification
The assertions assume the comparator is monotonic in `dac_code`: once the code is at or above the sensed level, the comparator stays true until the counter is cleared. They also assume every input changes away from the clock edge. The bench keeps to both conditions. It models the comparator as a combinational compare of `dac_code` against a target that changes only together with a `start` pulse or in the hold-stability test, which is run while a value is held. All inputs are driven on the falling edge.

// File: rtl/ocpsh_pkg.sv
package ocpsh_pkg;

    typedef enum logic [1:0] {
        SMP_IDLE = 2'd0,
        SMP_CONV = 2'd1,
        SMP_HOLD = 2'd2
    } smp_state_e;

    typedef struct packed {
        logic restart;
        logic step;
        logic capture;
    } smp_ctl_t;

    function automatic logic [7:0] max_code(input int unsigned w);
        return 8'((1 << w) - 1);
    endfunction

endpackage

// File: rtl/ocpsh_step_counter.sv
module ocpsh_step_counter #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              at_max
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    assign at_max = (code == TOP);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            code <= '0;
        end else if (step && !at_max) begin
            code <= code + 1'b1;
        end
    end
endmodule

// File: rtl/ocpsh_seq.sv
module ocpsh_seq
    import ocpsh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     por_good,
    input  logic     start,
    input  logic     cmp_reached,
    input  logic     conv_tick,
    input  logic     at_max,
    output smp_ctl_t ctl
);
    smp_state_e state_q, state_d;
    logic       converting;

    assign converting = (state_q == SMP_CONV) && por_good;

    always_comb begin
        ctl.restart = por_good && start;
        ctl.capture = converting && !ctl.restart &&
                      (cmp_reached || (conv_tick && at_max));
        ctl.step    = converting && !ctl.restart && !cmp_reached && conv_tick;
    end

    always_comb begin
        state_d = state_q;
        if (!por_good) begin
            state_d = SMP_IDLE;
        end else if (ctl.restart) begin
            state_d = SMP_CONV;
        end else if (ctl.capture) begin
            state_d = SMP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SMP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/ocpsh_hold.sv
module ocpsh_hold #(
    parameter int CODE_W   = 6,
    parameter int DIS_CODE = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_good,
    input  logic              restart,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] held,
    output logic              valid,
    output logic              done,
    output logic              disabled
);
    localparam logic [CODE_W-1:0] CEIL = CODE_W'(DIS_CODE);

    always_ff @(posedge clk) begin
        if (rst || !por_good || restart) begin
            held     <= '0;
            valid    <= 1'b0;
            done     <= 1'b0;
            disabled <= 1'b0;
        end else if (capture) begin
            held     <= code_in;
            valid    <= 1'b1;
            done     <= 1'b1;
            disabled <= (code_in >= CEIL);
        end else begin
            done     <= 1'b0;
        end
    end
endmodule

// File: rtl/ocp_setpoint_sampler.sv
module ocp_setpoint_sampler
    import ocpsh_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int DIS_CODE = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_good,
    input  logic              start,
    input  logic              conv_tick,
    input  logic              cmp_reached,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] held_code,
    output logic [CODE_W:0]   trip_level,
    output logic              sample_done,
    output logic              sample_valid,
    output logic              ocp_disabled
);
    localparam int TRIP_W = CODE_W + 1;

    smp_ctl_t ctl;
    logic     at_max;

    ocpsh_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .por_good   (por_good),
        .start      (start),
        .cmp_reached(cmp_reached),
        .conv_tick  (conv_tick),
        .at_max     (at_max),
        .ctl        (ctl)
    );

    ocpsh_step_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.restart || !por_good),
        .step  (ctl.step),
        .code  (dac_code),
        .at_max(at_max)
    );

    ocpsh_hold #(.CODE_W(CODE_W), .DIS_CODE(DIS_CODE)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .por_good(por_good),
        .restart (ctl.restart),
        .capture (ctl.capture),
        .code_in (dac_code),
        .held    (held_code),
        .valid   (sample_valid),
        .done    (sample_done),
        .disabled(ocp_disabled)
    );

    assign trip_level = TRIP_W'({held_code, 1'b0});
endmodule

// File: rtl/ocpsh_checker.sv
module ocpsh_checker #(
    parameter int CODE_W   = 6,
    parameter int DIS_CODE = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              por_good,
    input logic              start,
    input logic              conv_tick,
    input logic              cmp_reached,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] held_code,
    input logic [CODE_W:0]   trip_level,
    input logic              sample_done,
    input logic              sample_valid,
    input logic              ocp_disabled
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sample_done |=> !sample_done); // R3

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        sample_done |-> sample_valid); // R3

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && por_good && !start) |=> $stable(held_code)); // R5

    AST_DAC_STEP: assert property (@(posedge clk) disable iff (rst)
        (dac_code != $past(dac_code)) |->
            (dac_code == CODE_W'($past(dac_code) + 1'b1) || dac_code == '0)); // R2

    AST_TRIP_TWICE: assert property (@(posedge clk) disable iff (rst)
        trip_level[0] == 1'b0 && trip_level[CODE_W:1] == held_code); // R6

    AST_DIS_CEILING: assert property (@(posedge clk) disable iff (rst)
        ocp_disabled |-> (sample_valid && held_code >= CODE_W'(DIS_CODE))); // R7

    AST_POR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !por_good |=> (!sample_valid && held_code == '0 && dac_code == '0)); // R9

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (por_good && start) |=> (!sample_valid && dac_code == '0)); // R8
endmodule

bind ocp_setpoint_sampler ocpsh_checker #(.CODE_W(CODE_W), .DIS_CODE(DIS_CODE)) u_ocpsh_chk (.*);

// File: tb/ocp_setpoint_sampler_bench.sv
module ocp_setpoint_sampler_bench;
    localparam int CODE_W = 6;
    localparam int DIS    = 40;
    localparam int MAXC   = (1 << CODE_W) - 1;
    localparam int NV     = 10;

    // stimulus: target level, tick gap; expected: held code
    localparam int VEC_TGT [NV] = '{0, 1, 5, 17, 39, 40, 41, 63, 70, 25};
    localparam int VEC_GAP [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 2};
    localparam int VEC_EXP [NV] = '{0, 1, 5, 17, 39, 40, 41, 63, 63, 25};

    logic clk = 1'b0;
    logic rst, por_good, start, conv_tick, cmp_reached;
    logic [CODE_W-1:0] dac_code, held_code;
    logic [CODE_W:0]   trip_level;
    logic sample_done, sample_valid, ocp_disabled;
    int   target;
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc_total = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc_total <= cyc_total + 1;

    always_comb cmp_reached = (int'(dac_code) >= target);

    ocp_setpoint_sampler u_ocp_setpoint_sampler (
        .clk(clk), .rst(rst), .por_good(por_good), .start(start),
        .conv_tick(conv_tick), .cmp_reached(cmp_reached),
        .dac_code(dac_code), .held_code(held_code), .trip_level(trip_level),
        .sample_done(sample_done), .sample_valid(sample_valid),
        .ocp_disabled(ocp_disabled)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start(input int tgt);
        target = tgt;
        start  = 1'b1;
        tick_cycle();
        start  = 1'b0;
    endtask

    task automatic run_conv(input int tgt, input int gap, input int exp_held);
        int k = 0;
        pulse_start(tgt);
        check(dac_code == 0, "R2 start clears dac", int'(dac_code), 0);
        while (!sample_done && k < 300) begin
            conv_tick = (gap == 1) ? 1'b1 : 1'(k % 2);
            tick_cycle();
            k++;
        end
        conv_tick = 1'b0;
        check(held_code == CODE_W'(exp_held), "R3/R4 held code", int'(held_code), exp_held);
        check(sample_valid == 1'b1, "R3 valid", int'(sample_valid), 1);
        check(int'(trip_level) == 2 * exp_held, "R6 trip twice", int'(trip_level), 2 * exp_held);
        check(ocp_disabled == (exp_held >= DIS), "R7 disable flag", int'(ocp_disabled),
              int'(exp_held >= DIS));
        if (gap == 1) begin
            int t_exp = ((tgt > MAXC) ? MAXC : tgt) + 1;
            check(k == t_exp, "R3 conversion time", k, t_exp);
        end
        tick_cycle();
        check(sample_done == 1'b0, "R3 done one cycle", int'(sample_done), 0);
    endtask

    initial begin
        while (cyc_total < 100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc_total);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; por_good = 1'b1; start = 1'b0; conv_tick = 1'b0; target = 0;
        repeat (3) tick_cycle();
        check(dac_code == 0 && held_code == 0 && trip_level == 0 && !sample_done
              && !sample_valid && !ocp_disabled, "R1 reset state", int'(held_code), 0);
        rst = 1'b0;
        tick_cycle();
        check(!sample_valid && dac_code == 0, "R1 idle after reset", int'(sample_valid), 0);

        for (int i = 0; i < NV; i++) begin
            run_conv(VEC_TGT[i], VEC_GAP[i], VEC_EXP[i]);
        end

        // R5: hold stable while comparator and tick move
        run_conv(12, 1, 12);
        target = 0;
        conv_tick = 1'b1;
        repeat (10) tick_cycle();
        target = 60;
        repeat (10) tick_cycle();
        conv_tick = 1'b0;
        check(held_code == 12 && sample_valid, "R5 hold stable", int'(held_code), 12);
        check(dac_code == 12, "R5 dac frozen", int'(dac_code), 12);

        // R2: no tick means no step
        pulse_start(10);
        repeat (8) tick_cycle();
        check(dac_code == 0 && !sample_valid, "R2 no tick holds", int'(dac_code), 0);
        conv_tick = 1'b1;
        repeat (3) tick_cycle();
        check(dac_code == 3, "R2 steps per tick", int'(dac_code), 3);

        // R8: restart during conversion
        pulse_start(20);
        check(dac_code == 0 && !sample_valid, "R8 restart mid conv", int'(dac_code), 0);
        conv_tick = 1'b0;
        run_conv(20, 1, 20);

        // R8: restart while a value is held
        run_conv(45, 1, 45);
        pulse_start(8);
        check(!sample_valid && held_code == 0 && !ocp_disabled, "R8 restart clears hold",
              int'(held_code), 0);
        run_conv(8, 1, 8);

        // R9: POR loss clears, start ignored while low
        por_good = 1'b0;
        tick_cycle();
        check(!sample_valid && held_code == 0 && dac_code == 0, "R9 por clears",
              int'(held_code), 0);
        start = 1'b1; conv_tick = 1'b1; target = 50;
        repeat (5) tick_cycle();
        start = 1'b0;
        repeat (5) tick_cycle();
        check(dac_code == 0 && !sample_valid && !sample_done, "R9 start ignored",
              int'(dac_code), 0);
        conv_tick = 1'b0;
        por_good = 1'b1;
        tick_cycle();
        check(dac_code == 0 && !sample_valid, "R9 idle after por", int'(dac_code), 0);
        run_conv(30, 1, 30);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule